// File: doc/BRIEF.md
# Link Error Counter Bank

This block keeps nine independent error tallies for one PCM link. Each tally advances by one whenever its error input is high on a clock edge. The inputs are one-cycle pulses from the framer and line decoder: E-bit errors, errored frame alignment words, bipolar violations, CRC errors and five further sources. Software reaches everything through a simple register port. It can read any counter, or preset it to a chosen value. It can also set masks and hold every counter at zero through a master clear bit.

A once-per-second tick copies tallies 0 to 3 into a separate snapshot page, so software can read a consistent one-second picture at leisure. Tally 0 is the E-bit count, 1 the errored-alignment count, 2 the bipolar-violation count and 3 the CRC count. Two sticky flag sets, one for counted events and one for wraps, are cleared when they are read. The single interrupt line is the OR of every flag whose mask bit is set.

The design has no state machine. Its only sequencing is the priority order inside each counter: clear first, then write, then count.

Top module: `errcnt_bank`

## Requirements
- R1: After reset every counter, snapshot, flag set, mask and the control register read as zero, and `irq` is low.
- R2: A high `err_pulse[i]` on a clock edge adds one to counter i. Counter i reads at address i (0 to 8), zero-extended to 16 bits. Pulses on several inputs in the same cycle, or on consecutive cycles, are each counted.
- R3: A register write to address i presets counter i to `reg_wdata[7:0]`. If a pulse for the same counter arrives in the same cycle, the written value is kept and the pulse is neither counted nor flagged.
- R4: A counted pulse while a counter holds 255 makes it 0, and it goes on counting from there. The wrap sets bit i of the wrap flag set.
- R5: Bit 0 of the control register (address 17) is the master clear. While it is 1, all counters read 0, pulses are not counted and no event or wrap flags are set. Counting resumes once it is written back to 0.
- R6: On a `sec_tick` edge, counters 0 to 3 are copied into snapshot addresses 9 to 12. The copy holds each counter's value from before that edge. Snapshot values do not change until the next tick.
- R7: The wrap flag set reads at address 13, bit i for counter i, and the read clears it. A wrap in the same cycle as the read leaves its bit set afterwards.
- R8: The event flag set reads at address 14. Bit i is set by each counted pulse of counter i, and the read clears the set.
- R9: `irq` is high exactly when some bit of (wrap flags AND wrap mask at address 16) or of (event flags AND event mask at address 15) is 1. Mask bit i enables counter i.
- R10: Read data appears on `reg_rdata` in the cycle after `reg_rd` and holds until the next read. Writes to addresses 9 to 14 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pulse | input | 9 | One-cycle error pulses, bit i for counter i |
| sec_tick | input | 1 | One-second snapshot strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Combined masked interrupt |

## Verification
Counters, snapshots and flag sets change on the edge that samples a pulse, tick, write or read. `irq` follows from those flops in the same cycle, and `reg_rdata` is valid one edge after the read strobe. The bench drives every stimulus on a falling edge and samples results on the next falling edge, after exactly one rising edge. Same-cycle collisions are each set up in a single falling-edge slot: write against pulse, read against wrap, and tick against pulse.

// File: rtl/errcnt_pkg.sv
package errcnt_pkg;

    typedef enum logic [2:0] {
        RK_CNT,
        RK_SNAP,
        RK_OVF,
        RK_EVT,
        RK_EMSK,
        RK_OMSK,
        RK_CTRL,
        RK_NONE
    } reg_kind_e;

    // Address layout: counters, then snapshots, then flag sets, masks, control.
    function automatic reg_kind_e reg_classify(input logic [7:0] a,
                                               input int unsigned ncnt,
                                               input int unsigned nsnap);
        int unsigned ai;
        ai = 32'(a);
        if (ai < ncnt)                 return RK_CNT;
        else if (ai < ncnt + nsnap)    return RK_SNAP;
        else if (ai == ncnt + nsnap)   return RK_OVF;
        else if (ai == ncnt + nsnap + 1) return RK_EVT;
        else if (ai == ncnt + nsnap + 2) return RK_EMSK;
        else if (ai == ncnt + nsnap + 3) return RK_OMSK;
        else if (ai == ncnt + nsnap + 4) return RK_CTRL;
        else                           return RK_NONE;
    endfunction

endpackage

// File: rtl/errcnt_cell.sv
module errcnt_cell #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             evt,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic             counted,
    output logic             wrapped
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assign counted = evt && !wr && !clr;
    assign wrapped = counted && (cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clr)     cnt_q <= '0;
        else if (wr)      cnt_q <= wdata;
        else if (evt)     cnt_q <= cnt_q + 1'b1;
    end

    a_r5_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> (cnt_q == $past(wdata)));

    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrapped |=> (cnt_q == '0));

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (counted && !wrapped) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/errcnt_latch.sv
module errcnt_latch #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         rd_clr,
    output logic [N-1:0] lat_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= (rd_clr ? '0 : lat_q) | set;
    end

    a_r7_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((lat_q & $past(set)) == $past(set)));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> (($past(lat_q) & ~lat_q) == '0));

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && set == '0) |=> (lat_q == '0));

endmodule

// File: rtl/errcnt_bank.sv
module errcnt_bank
    import errcnt_pkg::*;
#(
    parameter int NUM_CNT = 9,
    parameter int CNT_W   = 8,
    parameter int SNAP_N  = 4,
    parameter int REG_W   = 16,
    parameter int ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] err_pulse,
    input  logic               sec_tick,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               irq
);
    logic [CNT_W-1:0]   cnt_q  [NUM_CNT];
    logic [CNT_W-1:0]   snap_q [SNAP_N];
    logic [NUM_CNT-1:0] counted, wrapped, cnt_wr;
    logic [NUM_CNT-1:0] ovf_lat, evt_lat, ovf_mask_q, evt_mask_q;
    logic               clr_q;
    reg_kind_e          kind;
    logic [REG_W-1:0]   rd_mux;
    logic               unused_wdata;

    assign kind         = reg_classify(8'(reg_addr), NUM_CNT, SNAP_N);
    assign unused_wdata = &{1'b0, reg_wdata[REG_W-1:NUM_CNT]};

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cell
        assign cnt_wr[i] = reg_wr && (reg_addr == ADDR_W'(i));
        errcnt_cell #(.CNT_W(CNT_W)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr_q),
            .evt     (err_pulse[i]),
            .wr      (cnt_wr[i]),
            .wdata   (reg_wdata[CNT_W-1:0]),
            .cnt_q   (cnt_q[i]),
            .counted (counted[i]),
            .wrapped (wrapped[i])
        );
    end

    errcnt_latch #(.N(NUM_CNT)) u_ovf_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (wrapped),
        .rd_clr (reg_rd && kind == RK_OVF),
        .lat_q  (ovf_lat)
    );

    errcnt_latch #(.N(NUM_CNT)) u_evt_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (counted),
        .rd_clr (reg_rd && kind == RK_EVT),
        .lat_q  (evt_lat)
    );

    always_ff @(posedge clk) begin
        for (int j = 0; j < SNAP_N; j++) begin
            if (!rst_n)        snap_q[j] <= '0;
            else if (sec_tick) snap_q[j] <= cnt_q[j];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_mask_q <= '0;
            evt_mask_q <= '0;
            clr_q      <= 1'b0;
        end else if (reg_wr) begin
            case (kind)
                RK_OMSK: ovf_mask_q <= reg_wdata[NUM_CNT-1:0];
                RK_EMSK: evt_mask_q <= reg_wdata[NUM_CNT-1:0];
                RK_CTRL: clr_q      <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        case (kind)
            RK_CNT:
                for (int i = 0; i < NUM_CNT; i++)
                    if (reg_addr == ADDR_W'(i)) rd_mux = REG_W'(cnt_q[i]);
            RK_SNAP:
                for (int j = 0; j < SNAP_N; j++)
                    if (reg_addr == ADDR_W'(NUM_CNT + j)) rd_mux = REG_W'(snap_q[j]);
            RK_OVF:  rd_mux = REG_W'(ovf_lat);
            RK_EVT:  rd_mux = REG_W'(evt_lat);
            RK_OMSK: rd_mux = REG_W'(ovf_mask_q);
            RK_EMSK: rd_mux = REG_W'(evt_mask_q);
            RK_CTRL: rd_mux = REG_W'(clr_q);
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    assign irq = (|(ovf_lat & ovf_mask_q)) || (|(evt_lat & evt_mask_q));

    for (genvar j = 0; j < SNAP_N; j++) begin : g_snap_chk
        a_r6_snap_capture: assert property (@(posedge clk) disable iff (!rst_n)
            sec_tick |=> (snap_q[j] == $past(cnt_q[j])));
        a_r6_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !sec_tick |=> $stable(snap_q[j]));
    end

    a_r9_irq_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_mask_q == '0 && evt_mask_q == '0) |-> !irq);

    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

endmodule

// File: tb/test_errcnt_bank.sv
module test_errcnt_bank;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  err_pulse = '0;
    logic        sec_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #(CLK_NS/2) clk = ~clk;

    errcnt_bank i_errcnt_bank (
        .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .sec_tick(sec_tick),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic reg_write(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = 16'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int a, output int d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 5'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        d = int'(reg_rdata);
    endtask

    task automatic pulse(input int m);
        @(negedge clk);
        err_pulse = 9'(m);
        @(negedge clk);
        err_pulse = '0;
    endtask

    task automatic t_reset();
        int d;
        check("R1 irq", int'(irq), 0);
        for (int a = 0; a < 18; a++) begin
            reg_read(a, d);
            check($sformatf("R1 addr %0d", a), d, 0);
        end
    endtask

    task automatic t_count();
        int d;
        pulse(9'h021);
        pulse(9'h001);
        pulse(9'h001);
        @(negedge clk); err_pulse = 9'h010;
        @(negedge clk);
        @(negedge clk); err_pulse = '0;
        reg_read(0, d); check("R2 counter0", d, 3);
        reg_read(5, d); check("R2 counter5", d, 1);
        reg_read(4, d); check("R2 counter4 back-to-back", d, 2);
        reg_read(1, d); check("R2 counter1 untouched", d, 0);
        reg_read(14, d); check("R8 event flags", d, 9'h031);
        reg_read(14, d); check("R8 event flags cleared", d, 0);
    endtask

    task automatic t_write();
        int d;
        reg_write(2, 8'h40);
        reg_read(2, d); check("R3 preset", d, 8'h40);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'd2; reg_wdata = 16'h0010; err_pulse = 9'h004;
        @(negedge clk);
        reg_wr = 1'b0; err_pulse = '0;
        reg_read(2, d); check("R3 write beats pulse", d, 8'h10);
        reg_read(14, d); check("R3 no event flag on collision", d, 0);
    endtask

    task automatic t_wrap();
        int d;
        reg_read(13, d);
        reg_write(7, 8'hFF);
        pulse(9'h080);
        reg_read(7, d); check("R4 wrap to zero", d, 0);
        reg_read(13, d); check("R4 wrap flag", d, 9'h080);
        reg_read(13, d); check("R7 read clears", d, 0);
        pulse(9'h080);
        reg_read(7, d); check("R4 keeps counting", d, 1);
    endtask

    task automatic t_race();
        int d;
        reg_write(8, 8'hFF);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 5'd13; err_pulse = 9'h100;
        @(negedge clk);
        reg_rd = 1'b0; err_pulse = '0;
        check("R7 read during wrap returns old", int'(reg_rdata), 0);
        reg_read(13, d); check("R7 new wrap survives read", d, 9'h100);
    endtask

    task automatic t_clear();
        int d;
        reg_write(0, 8'h55);
        reg_read(14, d);
        reg_write(17, 1);
        reg_read(0, d); check("R5 cleared", d, 0);
        pulse(9'h1FF);
        reg_read(3, d); check("R5 pulses ignored", d, 0);
        reg_read(14, d); check("R5 no event flags", d, 0);
        reg_read(17, d); check("R5 control readback", d, 1);
        reg_write(17, 0);
        pulse(9'h002);
        reg_read(1, d); check("R5 resumes", d, 1);
    endtask

    task automatic t_snap();
        int d;
        reg_write(0, 8'h11);
        reg_write(1, 8'h22);
        reg_write(2, 8'h33);
        reg_write(3, 8'h44);
        @(negedge clk);
        sec_tick = 1'b1; err_pulse = 9'h001;
        @(negedge clk);
        sec_tick = 1'b0; err_pulse = '0;
        reg_read(9, d);  check("R6 snap0 pre-edge", d, 8'h11);
        reg_read(0, d);  check("R6 counter0 advanced", d, 8'h12);
        reg_read(12, d); check("R6 snap3", d, 8'h44);
        pulse(9'h002);
        reg_read(10, d); check("R6 snap1 holds", d, 8'h22);
    endtask

    task automatic t_ro();
        int d;
        reg_read(14, d);
        reg_write(9, 16'hFFFF);
        reg_read(9, d); check("R10 snapshot read-only", d, 8'h11);
        reg_write(13, 16'hFFFF);
        reg_read(13, d); check("R10 wrap flags read-only", d, 0);
        reg_write(14, 16'hFFFF);
        reg_read(14, d); check("R10 event flags read-only", d, 0);
        @(negedge clk);
        check("R10 rdata holds", int'(reg_rdata), 0);
    endtask

    task automatic t_irq();
        int d;
        reg_read(13, d);
        reg_read(14, d);
        pulse(9'h008);
        check("R9 masked event no irq", int'(irq), 0);
        reg_write(15, 9'h008);
        check("R9 event mask raises irq", int'(irq), 1);
        reg_read(14, d);
        check("R9 irq drops after event read", int'(irq), 0);
        reg_write(6, 8'hFF);
        reg_write(16, 9'h040);
        pulse(9'h040);
        check("R9 wrap irq", int'(irq), 1);
        reg_read(13, d);
        check("R9 irq drops after wrap read", int'(irq), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_write();
        t_wrap();
        t_race();
        t_clear();
        t_snap();
        t_ro();
        t_irq();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule